// File: doc/BRIEF.md
# I2C Two-Stage Clock Divider

This block derives the timing references of an I2C controller from one system clock. A 7-bit control word holds two independently programmed fields. The exponent field sets a power-of-two prescaler. The prescaler emits a one-cycle sample strobe, which the controller uses to oversample the serial lines. The scalar field sets a second divider. That divider counts sample strobes and shapes them into a master-mode SCL waveform with equal high and low halves.

Because the two stages are separate, the line-sampling rate can stay high while SCL runs much slower. Every SCL period spans ten or more sample strobes, so a START or STOP condition from another master is never missed. The sample rate should be at least 1 MHz for standard-mode traffic up to 100 kbit/s, and at least 4 MHz for fast-mode traffic up to 400 kbit/s.

The block also gives a one-cycle strobe ahead of each SCL transition. The shifter and the detection logic can then act in step with the clock they drive.

Top module: `i2c_timebase`

## Requirements
- R1: The control word carries the scalar M (0 to 15) in bits [6:3] and the exponent N (0 to 7) in bits [2:0].
- R2: The sample strobe is high for exactly one cycle in every 2^N clock cycles. When N = 0 it is high on every cycle. Counting the first cycle after reset release as cycle 0, the strobes fall in the cycles c with c mod 2^N = 2^N-1.
- R3: While enabled, one SCL period spans 10·(M+1) sample strobes, which is 10·(M+1)·2^N clock cycles. SCL is high for the first 5·(M+1) strobes and low for the following 5·(M+1).
- R4: The rise strobe and the fall strobe are each one cycle wide and never high together. Each of them coincides with a sample strobe. SCL takes its new level at the clock edge that ends the strobe cycle.
- R5: While the synchronous reset is high, the sample, rise and fall strobes stay low. After reset release SCL is high and both counters start from zero.
- R6: While the enable input is low, SCL is high from the next cycle on and no rise or fall strobe is given. The sample strobe keeps its rate. When enable returns, SCL starts a full high half, counting from the first sample strobe seen with enable high.
- R7: While enabled, a new control word takes effect only after the rise strobe that closes the current SCL period. While disabled, it takes effect from the following cycle.
- R8: If N is lowered while disabled, and the prescaler count already meets or exceeds the new limit, a sample strobe is given in the first cycle under the new N. The count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Master-mode SCL generation enable |
| ctrl | input | 7 | Control word: scalar M in [6:3], exponent N in [2:0] |
| samp_stb | output | 1 | One-cycle line-sampling strobe |
| scl_o | output | 1 | Generated SCL level |
| scl_rise_stb | output | 1 | One-cycle strobe ahead of an SCL rising transition |
| scl_fall_stb | output | 1 | One-cycle strobe ahead of an SCL falling transition |

## Verification
The sample, rise and fall strobes are decoded from registered counter state, so each one appears in the same cycle as the count that produces it. SCL is registered and changes one edge after its strobe. A control word presented while disabled reaches the prescaler one edge later. All inputs are driven at the falling clock edge, and all outputs are sampled 2 ns later. Each check therefore compares with a closed-form expectation for that cycle index, computed from the floor of the cycle count divided by 2^N. Runs with a mid-period control change or an enable toggle use the same formulas, with the cycle index shifted to the point where the new setting takes hold.

// File: rtl/i2c_tb_pkg.sv
package i2c_tb_pkg;
   typedef enum logic {
      PH_HIGH = 1'b0,
      PH_LOW  = 1'b1
   } scl_phase_e;

   function automatic scl_phase_e other_phase(input scl_phase_e p);
      return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
   endfunction
endpackage

// File: rtl/i2c_tb_prescale.sv
module i2c_tb_prescale #(
   parameter int EXP_W = 3,
   localparam int CNT_W = (1 << EXP_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [EXP_W-1:0] exp_i,
   output logic             samp_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   // thermometer limit: 2^N - 1 built bit by bit
   for (genvar gi = 0; gi < CNT_W; gi++) begin : g_lim
      assign lim[gi] = (int'(exp_i) > gi);
   end

   // ">=" lets a lowered exponent fire at once instead of wrapping the count
   assign samp_o = !rst && (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (rst || samp_o) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/i2c_tb_cfg.sv
module i2c_tb_cfg #(
   parameter int CTRL_W = 7
) (
   input  logic              clk,
   input  logic              load,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [CTRL_W-1:0] act_o
);
   always_ff @(posedge clk) begin
      if (load) act_o <= ctrl_i;
   end
endmodule

// File: rtl/i2c_tb_phase.sv
module i2c_tb_phase
   import i2c_tb_pkg::*;
#(
   parameter int SCL_W    = 4,
   parameter int HALF_MUL = 5,
   localparam int HALF_MAX = HALF_MUL * (1 << SCL_W),
   localparam int HC_W     = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             samp_i,
   input  logic [SCL_W-1:0] m_i,
   output logic             scl_o,
   output logic             rise_o,
   output logic             fall_o
);
   scl_phase_e      ph_q;
   logic [HC_W-1:0] hcnt_q;
   logic [HC_W-1:0] half_last;
   logic            at_end;

   always_comb half_last = HC_W'(HALF_MUL * (int'(m_i) + 1) - 1);

   assign at_end = samp_i && en && (hcnt_q == half_last);
   assign rise_o = at_end && (ph_q == PH_LOW);
   assign fall_o = at_end && (ph_q == PH_HIGH);
   assign scl_o  = (ph_q == PH_HIGH);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         hcnt_q <= '0;
         ph_q   <= PH_HIGH;
      end else if (samp_i) begin
         if (hcnt_q == half_last) begin
            hcnt_q <= '0;
            ph_q   <= other_phase(ph_q);
         end else begin
            hcnt_q <= hcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_timebase.sv
module i2c_timebase #(
   parameter int EXP_W    = 3,
   parameter int SCL_W    = 4,
   parameter int HALF_MUL = 5,
   localparam int CTRL_W  = EXP_W + SCL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [CTRL_W-1:0] ctrl,
   output logic              samp_stb,
   output logic              scl_o,
   output logic              scl_rise_stb,
   output logic              scl_fall_stb
);
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("EXP_W must lie in 1..5");
   end
   if (SCL_W < 1 || SCL_W > 8) begin : g_bad_scl
      $error("SCL_W must lie in 1..8");
   end
   if (HALF_MUL < 1) begin : g_bad_mul
      $error("HALF_MUL must be at least 1");
   end

   logic [CTRL_W-1:0] act;
   logic              cfg_load;

   // period boundary, idle or reset: adopt the new control word
   assign cfg_load = rst || !en || scl_rise_stb;

   i2c_tb_cfg #(.CTRL_W(CTRL_W)) u_cfg (
      .clk    (clk),
      .load   (cfg_load),
      .ctrl_i (ctrl),
      .act_o  (act)
   );

   i2c_tb_prescale #(.EXP_W(EXP_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .exp_i  (act[EXP_W-1:0]),
      .samp_o (samp_stb)
   );

   i2c_tb_phase #(.SCL_W(SCL_W), .HALF_MUL(HALF_MUL)) u_ph (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .samp_i (samp_stb),
      .m_i    (act[CTRL_W-1:EXP_W]),
      .scl_o  (scl_o),
      .rise_o (scl_rise_stb),
      .fall_o (scl_fall_stb)
   );
endmodule

// File: rtl/i2c_timebase_chk.sv
module i2c_timebase_chk (
   input logic clk,
   input logic rst,
   input logic en,
   input logic samp_stb,
   input logic scl_o,
   input logic scl_rise_stb,
   input logic scl_fall_stb
);
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(scl_rise_stb && scl_fall_stb)); // R4
   AST_EDGE_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      (scl_rise_stb || scl_fall_stb) |-> samp_stb); // R4
   AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
      scl_fall_stb |=> !scl_o); // R4
   AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (rst)
      scl_rise_stb |=> scl_o); // R4
   AST_FELL_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      $fell(scl_o) |-> $past(scl_fall_stb)); // R3
   AST_IDLE_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
      !en |-> !(scl_rise_stb || scl_fall_stb)); // R6
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      !en |=> scl_o); // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |-> !(samp_stb || scl_rise_stb || scl_fall_stb)); // R5
endmodule

bind i2c_timebase i2c_timebase_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .en           (en),
   .samp_stb     (samp_stb),
   .scl_o        (scl_o),
   .scl_rise_stb (scl_rise_stb),
   .scl_fall_stb (scl_fall_stb)
);

// File: tb/sim_i2c_timebase.sv
module sim_i2c_timebase;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [6:0] ctrl = '0;
   logic       samp_stb, scl_o, scl_rise_stb, scl_fall_stb;
   int         total = 0;
   int         bad   = 0;
   bit         done  = 1'b0;

   always #5 clk = ~clk;

   i2c_timebase u0 (
      .clk          (clk),
      .rst          (rst),
      .en           (en),
      .ctrl         (ctrl),
      .samp_stb     (samp_stb),
      .scl_o        (scl_o),
      .scl_rise_stb (scl_rise_stb),
      .scl_fall_stb (scl_fall_stb)
   );

   function automatic logic [6:0] pack(input int n, input int m);
      return {m[3:0], n[2:0]};  // R1: M in [6:3], N in [2:0]
   endfunction

   task automatic ck(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // closed-form expectation for cycle c, SCL counting strobes from cycle e
   task automatic model(input string tag, input int c, input int n, input int m, input int e);
      int p, h, k, s;
      p = 1 << n;
      h = 5 * (m + 1);
      s = ((c % p) == p - 1) ? 1 : 0;
      k = c / p - e / p;
      ck({tag, " R2 samp"}, int'(samp_stb), s);
      ck({tag, " R3 scl"}, int'(scl_o), ((k % (2*h)) < h) ? 1 : 0);
      ck({tag, " R4 rise"}, int'(scl_rise_stb), (s == 1 && (k % (2*h)) == 2*h - 1) ? 1 : 0);
      ck({tag, " R4 fall"}, int'(scl_fall_stb), (s == 1 && (k % (2*h)) == h - 1) ? 1 : 0);
   endtask

   // ends at the falling edge of cycle 0 with reset released
   task automatic start(input int n, input int m, input bit en0);
      @(negedge clk);
      rst  = 1'b1;
      en   = en0;
      ctrl = pack(n, m);
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic sweep_one(input int n, input int m);
      int per;
      per = 10 * (m + 1) * (1 << n);
      start(n, m, 1'b1);
      for (int c = 0; c < 2 * per + 4; c++) begin
         if (c > 0) @(negedge clk);
         #2;
         model($sformatf("R1 sweep n=%0d m=%0d", n, m), c, n, m, 0);
      end
   endtask

   initial begin
      // reset state, N=0 would otherwise strobe every cycle
      rst = 1'b1; en = 1'b1; ctrl = pack(0, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #2;
         ck("R5 reset samp", int'(samp_stb), 0);
         ck("R5 reset rise", int'(scl_rise_stb), 0);
         ck("R5 reset fall", int'(scl_fall_stb), 0);
         if (i > 0) ck("R5 reset scl", int'(scl_o), 1);
      end

      // near-exhaustive sweep of M for small N, plus large-N corners
      for (int n = 0; n < 4; n++)
         for (int m = 0; m < 16; m++)
            sweep_one(n, m);
      sweep_one(7, 0);
      sweep_one(5, 15);

      // R6: enable low, high at 13, low at 40, high again at 50
      start(1, 0, 1'b0);
      for (int c = 0; c < 100; c++) begin
         if (c > 0) @(negedge clk);
         en = ((c >= 13 && c < 40) || c >= 50);
         #2;
         if (c >= 13 && c < 40)      model("R6 run1", c, 1, 0, 13);
         else if (c >= 50)           model("R6 run2", c, 1, 0, 50);
         else begin
            ck("R6 idle samp", int'(samp_stb), ((c % 2) == 1) ? 1 : 0);
            ck("R6 idle rise", int'(scl_rise_stb), 0);
            ck("R6 idle fall", int'(scl_fall_stb), 0);
            if (c != 40) ck("R6 idle scl", int'(scl_o), 1);
         end
      end
      en = 1'b0;

      // R7: change at cycle 7 holds until the period ends at cycle 19
      start(1, 0, 1'b1);
      for (int c = 0; c < 90; c++) begin
         if (c > 0) @(negedge clk);
         if (c == 7) ctrl = pack(0, 1);
         #2;
         if (c < 20) model("R7 old cfg", c, 1, 0, 0);
         else        model("R7 new cfg", c - 20, 0, 1, 0);
      end

      // R8: exponent lowered from 3 to 1 while idle, count already at 6
      start(3, 0, 1'b0);
      for (int c = 0; c < 21; c++) begin
         if (c > 0) @(negedge clk);
         if (c == 5) ctrl = pack(1, 0);
         #2;
         ck("R8 samp", int'(samp_stb), (c >= 6 && ((c - 6) % 2) == 0) ? 1 : 0);
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule